// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block produces a periodic interrupt from a down-counter. An 8-bit divide value sets how many clock cycles pass between counter steps: the counter steps once every (divide value + 1) cycles. When a step finds the counter at 1 or at 0, the counter reloads itself from a separate period register and emits a one-cycle interrupt pulse. Counting then continues without any action from software. The live counter can be written directly. The period register is read only when a reload happens.

Software reaches the block through a single-cycle write port. A 2-bit select picks one of four targets: the control word, the divide value, the live counter or the reload period. Bit 0 of the control word drives a two-state machine. In `ST_HALT` nothing moves. In `ST_RUN` the prescaler and counter advance. The transition `ST_HALT -> ST_RUN` occurs on a control write with bit 0 set. The transition `ST_RUN -> ST_HALT` occurs on a control write with bit 0 clear. All other writes leave the state unchanged. The new state governs counting from the clock edge after the write.

Top module: `interval_timer`

## Requirements
- R1: After reset the live counter, divide value and reload period are all zero, the machine is in `ST_HALT` (`run_o` low) and `irq_o` is low.
- R2: A write with `wr_en` high stores `wr_data` into the target named by `wr_sel` and nothing else. The encodings are: 0 = control (bit 0 = run), 1 = divide value (bits 7:0), 2 = live counter (bits 15:0), 3 = reload period (bits 15:0).
- R3: In `ST_RUN` the live counter steps down by one once every (divide value + 1) clock cycles. The prescaler fires when its phase is greater than or equal to the divide value, and then returns to phase 0.
- R4: A step that finds the counter at 1 or 0 loads the counter with the reload period instead of decrementing it. `irq_o` is high for exactly the following cycle.
- R5: With reload period P ≥ 1, interrupts repeat every P × (divide value + 1) cycles with no software writes. With P = 0, every step raises an interrupt.
- R6: A write to the live counter takes effect at the next edge, even while running. It resets the prescaler phase to 0 and suppresses any step and interrupt in that cycle.
- R7: A write to the reload period does not change the live counter. It is used only at the next reload.
- R8: In `ST_HALT` the prescaler phase and the counter hold their values and `irq_o` stays low. A control write takes effect for counting from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 16 | Write data |
| irq_o | output | 1 | One-cycle interrupt pulse |
| count_o | output | 16 | Live counter value |
| run_o | output | 1 | High in `ST_RUN` |

## Verification
The bench runs a table of divide, period and start values. These include divide 0 and 255, period 0, 1 and 65535, and a start count of 0. For each entry it compares the number of interrupts and the final counter with a step-by-step model. A prescaler that divides by the divide value instead of by value + 1 shows up here as a wrong interrupt count. So does a reload that waits for an extra step at zero. Directed tests write the counter in mid-run and change the period just before a reload. They catch a prescaler that keeps its phase after a counter write. They also catch a period write that leaks into the live counter, an interrupt that lasts longer than one cycle, and a halted timer that keeps counting.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int SEL_W = 2;

    localparam logic [SEL_W-1:0] SEL_CTRL   = 2'd0;
    localparam logic [SEL_W-1:0] SEL_SCALE  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_COUNT  = 2'd2;
    localparam logic [SEL_W-1:0] SEL_PERIOD = 2'd3;

    localparam int NUM_SEL = 1 << SEL_W;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_bit,
    output logic run
);

    tmr_state_e state_q;
    tmr_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (ctl_wr && ctl_bit)  state_d = ST_RUN;
            ST_RUN:  if (ctl_wr && !ctl_bit) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_HALT: run = 1'b0;
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SCL_W-1:0] scale,
    output logic             tick
);

    localparam logic [SCL_W-1:0] PH_ONE = SCL_W'(1);

    logic [SCL_W-1:0] phase_q;

    // a phase at or above the divide value fires, so lowering the
    // divide value below the current phase fires on the next cycle
    assign tick = run && !restart && (phase_q >= scale);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run) begin
            if (tick) phase_q <= '0;
            else      phase_q <= phase_q + PH_ONE;
        end
    end

endmodule

// File: rtl/tmr_down.sv
module tmr_down #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count_q,
    output logic             irq_q
);

    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

    logic expire;

    // a step at 1 (or at 0 after a direct load of 0) reloads
    assign expire = tick && !load_en && (count_q <= C_ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= expire;
            if (load_en) begin
                count_q <= load_val;
            end else if (expire) begin
                count_q <= period;
            end else if (tick) begin
                count_q <= count_q - C_ONE;
            end
        end
    end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             irq_o,
    output logic [CNT_W-1:0] count_o,
    output logic             run_o
);

    logic [NUM_SEL-1:0] hit;
    logic [SCL_W-1:0]   scale_q;
    logic [CNT_W-1:0]   period_q;
    logic               run;
    logic               tick;

    // one-hot write decode
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_dec
        assign hit[i] = wr_en && (wr_sel == SEL_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scale_q  <= '0;
            period_q <= '0;
        end else begin
            if (hit[SEL_SCALE])  scale_q  <= wr_data[SCL_W-1:0];
            if (hit[SEL_PERIOD]) period_q <= wr_data;
        end
    end

    tmr_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (hit[SEL_CTRL]),
        .ctl_bit (wr_data[0]),
        .run     (run)
    );

    tmr_prescale #(.SCL_W(SCL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (hit[SEL_COUNT]),
        .scale   (scale_q),
        .tick    (tick)
    );

    tmr_down #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load_en  (hit[SEL_COUNT]),
        .load_val (wr_data),
        .period   (period_q),
        .count_q  (count_o),
        .irq_q    (irq_o)
    );

    assign run_o = run;

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic             irq_o,
    input logic [CNT_W-1:0] count_o,
    input logic             run_o,
    input logic [CNT_W-1:0] period_q
);

    logic cnt_wr;
    assign cnt_wr = wr_en && (wr_sel == SEL_COUNT);

    // R4
    irq_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> count_o == $past(period_q));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !cnt_wr) |=> $stable(count_o));

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |=> !irq_o);

    // R6
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> count_o == $past(wr_data));

    // R3
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !cnt_wr) |=> (irq_o || count_o == $past(count_o)
                                || count_o == $past(count_o) - CNT_W'(1)));

endmodule

bind interval_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .irq_o    (irq_o),
    .count_o  (count_o),
    .run_o    (run_o),
    .period_q (period_q)
);

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
    import tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        irq_o;
    logic [15:0] count_o;
    logic        run_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    interval_timer dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .irq_o   (irq_o),
        .count_o (count_o),
        .run_o   (run_o)
    );

    // {divide[8], period[16], start[16], edges[16]}
    localparam int NVEC = 8;
    localparam logic [55:0] VEC [NVEC] = '{
        {8'd0,   16'd5,     16'd5,  16'd23},
        {8'd3,   16'd4,     16'd2,  16'd40},
        {8'd1,   16'd0,     16'd3,  16'd12},
        {8'd7,   16'd10,    16'd10, 16'd200},
        {8'd255, 16'd2,     16'd1,  16'd600},
        {8'd2,   16'd1,     16'd1,  16'd15},
        {8'd0,   16'd65535, 16'd3,  16'd10},
        {8'd4,   16'd3,     16'd0,  16'd30}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // step-by-step model of the requirements, n counting edges
    function automatic void model(input int s, input int p, input int c,
                                  input int n, output int irqs, output int fin);
        int ph = 0;
        irqs = 0;
        fin  = c;
        for (int k = 0; k < n; k++) begin
            if (ph >= s) begin
                ph = 0;
                if (fin <= 1) begin fin = p; irqs++; end
                else fin = fin - 1;
            end else begin
                ph++;
            end
        end
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int s, p, c, n, irqs, exp_irqs, exp_fin, hold;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset values
        chk("R1 count", int'(count_o), 0);
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 run", int'(run_o), 0);
        // R1 divide 0 and period 0 after reset
        wr(SEL_COUNT, 16'd2);
        wr(SEL_CTRL, 16'd1);
        step(1);
        chk("R1 step every cycle", int'(count_o), 1);
        step(1);
        chk("R1 reload from zero period", int'(count_o), 0);
        chk("R4 irq on reload", int'(irq_o), 1);
        wr(SEL_CTRL, 16'd0);
        chk("R8 halted", int'(run_o), 0);

        // R2 a divide write leaves the counter alone
        wr(SEL_COUNT, 16'd77);
        wr(SEL_SCALE, 16'd9);
        chk("R2 divide write", int'(count_o), 77);

        // vector table: R3 final count, R5 interrupt count
        for (int v = 0; v < NVEC; v++) begin
            s = int'(VEC[v][55:48]);
            p = int'(VEC[v][47:32]);
            c = int'(VEC[v][31:16]);
            n = int'(VEC[v][15:0]);
            wr(SEL_SCALE, 16'(s));
            wr(SEL_PERIOD, 16'(p));
            wr(SEL_COUNT, 16'(c));
            wr(SEL_CTRL, 16'd1);
            irqs = 0;
            for (int k = 0; k < n; k++) begin
                if (k == n - 1) begin
                    wr_en = 1'b1; wr_sel = SEL_CTRL; wr_data = 16'd0;
                end
                @(negedge clk);
                wr_en = 1'b0;
                if (irq_o) irqs++;
            end
            model(s, p, c, n, exp_irqs, exp_fin);
            chk("R5 interrupt count", irqs, exp_irqs);
            chk("R3 final count", int'(count_o), exp_fin);
        end

        // R8 halted timer holds and stays quiet
        hold = int'(count_o);
        irqs = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (irq_o) irqs++;
        end
        chk("R8 hold count", int'(count_o), hold);
        chk("R8 no irq", irqs, 0);

        // R6 counter write in mid-run restarts the prescaler
        wr(SEL_SCALE, 16'd3);
        wr(SEL_PERIOD, 16'd20);
        wr(SEL_COUNT, 16'd10);
        wr(SEL_CTRL, 16'd1);
        step(6);
        chk("R3 divide 3 step", int'(count_o), 9);
        wr(SEL_COUNT, 16'd2);
        chk("R6 immediate load", int'(count_o), 2);
        step(3);
        chk("R6 phase restarted", int'(count_o), 2);
        step(1);
        chk("R6 first step after load", int'(count_o), 1);
        wr(SEL_CTRL, 16'd0);

        // R7 period write just before a reload
        wr(SEL_SCALE, 16'd0);
        wr(SEL_PERIOD, 16'd4);
        wr(SEL_COUNT, 16'd3);
        wr(SEL_CTRL, 16'd1);
        step(1);
        wr(SEL_PERIOD, 16'd9);
        chk("R7 counter untouched", int'(count_o), 1);
        step(1);
        chk("R7 new period used", int'(count_o), 9);
        chk("R4 irq high", int'(irq_o), 1);
        step(1);
        chk("R4 irq single cycle", int'(irq_o), 0);
        chk("R4 count after reload", int'(count_o), 8);
        wr(SEL_CTRL, 16'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule